// File: doc/BRIEF.md
# Split 64-bit Register Bridge

This block keeps three 64-bit registers behind a 32-bit memory-mapped bus: a general configuration register, a control register, and a free-running 64-bit event counter. Each 64-bit value occupies two consecutive 32-bit words. The word at offset +0 carries bits 63..32 and the word at offset +4 carries bits 31..0.

Writes are two-phase. A write to the +0 word of a writable register only loads a single shared staging word. A write to the +4 word commits the staged word and the new low word into the 64-bit register in one step. Bit 31 of the control register's low word is a software-reset command. It raises a reset output for exactly one cycle and then clears itself.

Reads are coherent for the counter. Reading its +0 word also captures the low half of the counter. The next read of its +4 word returns that captured half, so both halves come from the same sample even while events keep arriving.

Top module: `split_reg_bridge`

## Requirements
- R1: After reset, cfg_o, ctrl_o, the counter and the staging word are zero, swrst_o is low and rsp_valid_o is low.
- R2: A request is decoded from byte address bits 4..3: 0 selects the configuration register, 1 the control register, 2 the event counter. Bit 2 picks the half: 0 means bits 63..32, 1 means bits 31..0. A read returns its data on rsp_rdata_o, with rsp_valid_o high, in the cycle after the request is accepted.
- R3: A write to the +0 word of the configuration or control register loads only the staging word. The upper halves of cfg_o and ctrl_o stay unchanged.
- R4: A write to the +4 word of the configuration or control register sets the whole 64-bit value to {staging word, write data}, visible on cfg_o or ctrl_o from the next cycle.
- R5: The staging word keeps its value after a commit, so a +4 write on its own commits with the last staged upper word, which is zero if nothing has been staged since reset.
- R6: The counter increases by one on every clock edge where event_i is high and holds otherwise. Writes to either counter word change neither the counter nor the staging word.
- R7: A read of the counter's +0 word returns the live bits 63..32 and arms a capture of bits 31..0. The next read of the counter's +4 word returns that captured value, even if the counter has advanced or other registers were read in between.
- R8: A read of the counter's +4 word with no armed capture returns the live bits 31..0. Any read of the counter's +4 word consumes the capture.
- R9: Committing the control register with bit 31 of the low word set drives swrst_o high for exactly one cycle. Bit 31 of ctrl_o then clears itself, and the other committed bits are kept.
- R10: An address with bits 4..3 equal to 3, a nonzero bit 1 or 0, or any bit above 4 set is unmapped. Reads return zero, and writes change no register and not the staging word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus request valid this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DW | Write data word |
| rsp_rdata_o | output | DW | Read data, registered |
| rsp_valid_o | output | 1 | Read data valid |
| event_i | input | 1 | Counter increment strobe |
| cfg_o | output | 2*DW | Configuration register value |
| ctrl_o | output | 2*DW | Control register value |
| swrst_o | output | 1 | One-cycle software reset pulse |

## Verification
The hardest case to reach from the ports is a paired counter read whose two halves would differ if taken live. This needs event_i held high across the gap between the +0 and +4 reads, with unrelated reads placed in between that must not consume the capture. Directed sequences build exactly that gap. Constrained-random traffic then interleaves reads, writes, idle cycles and event strobes over all addresses. A bench model tracks the staging word, the capture and its armed state, and predicts every read.

// File: rtl/sr_bridge_pkg.sv
package sr_bridge_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int SEL_LSB  = 3;
  localparam int HALF_BIT = 2;
  localparam int MAP_BITS = 5;
endpackage

// File: rtl/sr_stage.sv
module sr_stage #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] stage_o
);
  logic [DW-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (load_i) stage_q <= data_i;
  end

  assign stage_o = stage_q;

  // R5: staged word persists until the next +0 write
  p_stage_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(stage_o));
endmodule

// File: rtl/sr_commit_reg.sv
module sr_commit_reg #(
  parameter int DW      = 32,
  parameter int CLR_BIT = -1,
  localparam int RW     = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [DW-1:0] upper_i,
  input  logic [DW-1:0] lower_i,
  output logic [RW-1:0] value_o
);
  logic [RW-1:0] value_q;

  generate
    if (CLR_BIT >= 0) begin : g_selfclr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       value_q <= '0;
        else if (commit_i) value_q <= {upper_i, lower_i};
        else               value_q[CLR_BIT] <= 1'b0;
      end

      p_selfclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        value_q[CLR_BIT] && !commit_i |=> !value_q[CLR_BIT]);
      p_set_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(value_q[CLR_BIT]) |-> $past(commit_i));
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       value_q <= '0;
        else if (commit_i) value_q <= {upper_i, lower_i};
      end
    end
  endgenerate

  assign value_o = value_q;

  p_commit_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> value_o[RW-1:DW] == $past(upper_i));
  p_hold_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(value_o[RW-1:DW]));
endmodule

// File: rtl/sr_event_ctr.sv
module sr_event_ctr #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         event_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (event_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> count_o == $past(count_o) + 1'b1);
  p_count_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> $stable(count_o));
endmodule

// File: rtl/sr_read_path.sv
module sr_read_path
  import sr_bridge_pkg::*;
#(
  parameter int DW  = 32,
  localparam int RW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  reg_sel_e      sel_i,
  input  logic          upper_i,
  input  logic [RW-1:0] cfg_i,
  input  logic [RW-1:0] ctrl_i,
  input  logic [RW-1:0] cnt_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] snap_lo_q;
  logic          armed_q;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;
  logic [DW-1:0] rd_mux;
  logic          cnt_rd;

  assign cnt_rd = rd_i && (sel_i == SEL_CNT);

  always_comb begin
    unique case (sel_i)
      SEL_CFG:  rd_mux = upper_i ? cfg_i[RW-1:DW]  : cfg_i[DW-1:0];
      SEL_CTRL: rd_mux = upper_i ? ctrl_i[RW-1:DW] : ctrl_i[DW-1:0];
      SEL_CNT:  rd_mux = upper_i ? cnt_i[RW-1:DW]
                                 : (armed_q ? snap_lo_q : cnt_i[DW-1:0]);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_lo_q <= '0;
      armed_q   <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
      if (cnt_rd) begin
        // upper half is returned live; only the low half needs capturing
        if (upper_i) begin
          snap_lo_q <= cnt_i[DW-1:0];
          armed_q   <= 1'b1;
        end else begin
          armed_q   <= 1'b0;
        end
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  p_no_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && sel_i == SEL_NONE |=> rdata_o == '0);
  p_bare_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rd && !upper_i && !armed_q |=> rdata_o == $past(cnt_i[DW-1:0]));
  p_snap_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rd && !upper_i && armed_q |=> rdata_o == $past(snap_lo_q));
  p_disarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rd && !upper_i |=> !armed_q);
endmodule

// File: rtl/split_reg_bridge.sv
module split_reg_bridge
  import sr_bridge_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_valid_o,
  input  logic              event_i,
  output logic [2*DW-1:0]   cfg_o,
  output logic [2*DW-1:0]   ctrl_o,
  output logic              swrst_o
);
  localparam int RW        = 2 * DW;
  localparam int SWRST_BIT = DW - 1;

  logic          wr, rd, addr_ok, upper, writable;
  reg_sel_e      sel;
  logic [DW-1:0] stage;
  logic [RW-1:0] cfg_q, ctrl_q, cnt_q;

  assign wr      = req_valid_i && req_write_i;
  assign rd      = req_valid_i && !req_write_i;
  assign addr_ok = (req_addr_i[HALF_BIT-1:0] == '0) && ((req_addr_i >> MAP_BITS) == '0);
  assign sel     = addr_ok ? reg_sel_e'(req_addr_i[SEL_LSB+1:SEL_LSB]) : SEL_NONE;
  assign upper   = !req_addr_i[HALF_BIT];
  assign writable = (sel == SEL_CFG) || (sel == SEL_CTRL);

  sr_stage #(.DW(DW)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr && writable && upper),
    .data_i  (req_wdata_i),
    .stage_o (stage)
  );

  sr_commit_reg #(.DW(DW), .CLR_BIT(-1)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (wr && (sel == SEL_CFG) && !upper),
    .upper_i  (stage),
    .lower_i  (req_wdata_i),
    .value_o  (cfg_q)
  );

  sr_commit_reg #(.DW(DW), .CLR_BIT(SWRST_BIT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (wr && (sel == SEL_CTRL) && !upper),
    .upper_i  (stage),
    .lower_i  (req_wdata_i),
    .value_o  (ctrl_q)
  );

  sr_event_ctr #(.W(RW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .count_o (cnt_q)
  );

  sr_read_path #(.DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd),
    .sel_i    (sel),
    .upper_i  (upper),
    .cfg_i    (cfg_q),
    .ctrl_i   (ctrl_q),
    .cnt_i    (cnt_q),
    .rdata_o  (rsp_rdata_o),
    .rvalid_o (rsp_valid_o)
  );

  assign cfg_o   = cfg_q;
  assign ctrl_o  = ctrl_q;
  assign swrst_o = ctrl_q[SWRST_BIT];

  p_stage_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && writable && upper |=> $stable(cfg_o) && $stable(ctrl_o[RW-1:DW]));
  p_ignored_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !writable |=> $stable(cfg_o) && $stable(stage));
  p_swrst_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o && !(wr && sel == SEL_CTRL && !upper) |=> !swrst_o);
endmodule

// File: tb/split_reg_bridge_test.sv
module split_reg_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_write_i, event_i;
  logic [4:0]  req_addr_i;
  logic [31:0] req_wdata_i;
  logic [31:0] rsp_rdata_o;
  logic        rsp_valid_o;
  logic [63:0] cfg_o, ctrl_o;
  logic        swrst_o;

  int n_checks = 0;
  int n_err    = 0;

  logic [63:0] m_cfg, m_ctrl, m_cnt;
  logic [31:0] m_stage, m_snap;
  bit          m_armed;

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_reg_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o),
    .rsp_valid_o(rsp_valid_o), .event_i(event_i), .cfg_o(cfg_o), .ctrl_o(ctrl_o),
    .swrst_o(swrst_o)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [63:0] v, input bit up);
    return up ? v[63:32] : v[31:0];
  endfunction

  // one bus cycle; entered and left at a falling edge
  task automatic do_op(input bit v, input bit w, input logic [4:0] a,
                       input logic [31:0] d, input bit ev, input string tag);
    logic [31:0] exp_rd;
    logic [63:0] nctrl;
    bit up;
    bit [1:0] sel;
    req_valid_i = v; req_write_i = w; req_addr_i = a; req_wdata_i = d; event_i = ev;
    @(posedge clk);
    up  = !a[2];
    sel = (a[1:0] != 2'b00) ? 2'd3 : a[4:3];
    exp_rd = '0;
    if (v && !w) begin
      case (sel)
        2'd0: exp_rd = pick(m_cfg, up);
        2'd1: exp_rd = pick(m_ctrl, up);
        2'd2: begin
          if (up) begin
            exp_rd = m_cnt[63:32]; m_snap = m_cnt[31:0]; m_armed = 1;
          end else begin
            exp_rd = m_armed ? m_snap : m_cnt[31:0]; m_armed = 0;
          end
        end
        default: exp_rd = '0;
      endcase
    end
    nctrl = m_ctrl;
    nctrl[31] = 1'b0;
    if (v && w && sel < 2) begin
      if (up) m_stage = d;
      else if (sel == 0) m_cfg = {m_stage, d};
      else nctrl = {m_stage, d};
    end
    m_ctrl = nctrl;
    if (ev) m_cnt = m_cnt + 64'd1;
    @(negedge clk);
    chk(tag, "cfg_o", cfg_o, m_cfg);
    chk(tag, "ctrl_o", ctrl_o, m_ctrl);
    chk(tag, "swrst_o", {63'd0, swrst_o}, {63'd0, m_ctrl[31]});
    chk(tag, "rsp_valid_o", {63'd0, rsp_valid_o}, {63'd0, v && !w});
    if (v && !w) chk(tag, "rsp_rdata_o", {32'd0, rsp_rdata_o}, {32'd0, exp_rd});
    req_valid_i = 0; event_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, input bit ev, input string tag);
    do_op(1, 0, a, 32'h0, ev, tag);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    do_op(1, 1, a, d, 0, tag);
  endtask
  task automatic idle(input bit ev, input string tag);
    do_op(0, 0, 5'h0, 32'h0, ev, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_cfg = '0; m_ctrl = '0; m_cnt = '0; m_stage = '0; m_snap = '0; m_armed = 0;
    rst_ni = 0; req_valid_i = 0; req_write_i = 0; req_addr_i = '0; req_wdata_i = '0;
    event_i = 0;
    repeat (3) @(negedge clk);
    // R1: state while reset is still applied
    chk("R1", "cfg_o", cfg_o, 64'd0);
    chk("R1", "ctrl_o", ctrl_o, 64'd0);
    chk("R1", "swrst_o", {63'd0, swrst_o}, 64'd0);
    chk("R1", "rsp_valid_o", {63'd0, rsp_valid_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) rd(5'(i * 4), 0, "R1");

    wr(5'h04, 32'h0000_1111, "R5");   // zero stage after reset
    wr(5'h00, 32'hA5A5_0001, "R3");   // staged only
    wr(5'h04, 32'h5A5A_0002, "R4");
    wr(5'h04, 32'h0000_0003, "R5");   // stage reused
    rd(5'h00, 0, "R2");
    rd(5'h04, 0, "R2");
    rd(5'h08, 0, "R2");

    for (int i = 0; i < 10; i++) idle(1, "R6");
    wr(5'h10, 32'hFFFF_FFFF, "R6");
    wr(5'h14, 32'hFFFF_FFFF, "R6");
    rd(5'h14, 0, "R6");
    wr(5'h04, 32'h0000_0007, "R6");   // stage untouched by counter writes

    rd(5'h10, 1, "R7");
    for (int i = 0; i < 5; i++) idle(1, "R7");
    rd(5'h00, 1, "R7");               // other reads keep the capture
    rd(5'h14, 1, "R7");
    rd(5'h14, 1, "R8");
    rd(5'h14, 0, "R8");

    wr(5'h08, 32'h0000_1234, "R9");
    wr(5'h0C, 32'h8000_0055, "R9");
    idle(0, "R9");
    idle(0, "R9");
    wr(5'h0C, 32'h0000_0066, "R9");
    rd(5'h0C, 0, "R9");

    wr(5'h18, 32'hDEAD_BEEF, "R10");
    wr(5'h1C, 32'hDEAD_BEEF, "R10");
    wr(5'h01, 32'hCAFE_F00D, "R10");
    rd(5'h18, 0, "R10");
    rd(5'h1E, 0, "R10");
    wr(5'h04, 32'h0000_0009, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      bit v, w;
      string tag;
      a = {2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 2'b00};
      v = ($urandom_range(0, 9) < 8);
      w = ($urandom_range(0, 2) == 0);
      if (a[4:3] == 2'd2) tag = a[2] ? "R8" : "R7";
      else if (a[4:3] == 2'd3) tag = "R10";
      else tag = w ? "R4" : "R2";
      do_op(v, w, a, (($urandom_range(0, 3) == 0) ? 32'h8000_0000 : 32'h0) | 32'($urandom()),
            1'($urandom_range(0, 1)), tag);
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule